// File: doc/BRIEF.md
# Flash Word Programming Sequencer

This block runs on the host side and writes a range of words into an external NOR-style flash. It is given a first address, a last address and a word source, which it reads through an address and data pair. For each address it writes the program command sequence on a simple single-cycle flash bus, polls the device until the internal write finishes, reads the whole word back to compare it, and then steps to the next address. The run ends when the last address is programmed or when an error stops it.

Completion is detected by data polling. While the device is busy, status bit 7 of a read returns the complement of the bit being written. When the write has finished, bit 7 reads back the true value. A failed compare does not skip the word. The sequencer polls again and compares again, up to a set number of retries. A poll that never completes ends the run with a timeout. A `bypass` input selects the short two-write command form in place of the four-write unlock form.

Top module: `flash_prog_seq`

## Requirements
- R1: After reset the block is idle. `busy`, `done`, `error`, `fl_we` and `fl_re` are low, and `err_code` is 00.
- R2: With `bypass` low at start, each word is programmed by exactly four writes in this order: (UNLK_A, AAh), (UNLK_B, 55h), (UNLK_A, A0h), then (word address, source data). UNLK_A defaults to 555h and UNLK_B to 2AAh.
- R3: With `bypass` high at start, each word is programmed by exactly two writes: (UNLK_A, A0h), then (word address, source data).
- R4: Each status read uses the word's address. Read data is taken in the cycle after the `fl_re` cycle. A poll counts as complete when bit 7 of the read equals bit 7 of the source word.
- R5: After a complete poll, a full-word read is compared with the source word. If it differs, the block returns to polling and compares again. A word whose compare fails at most RETRY_MAX times still completes.
- R6: Addresses from `first_addr` up to `last_addr` inclusive are programmed once each, in ascending order. The block then holds `done` high and `busy` low.
- R7: If POLL_LIMIT polls in a row all show busy, the block stops. It raises `error` with `err_code` 01 and `err_addr` equal to the word's address, and makes no further bus access.
- R8: If the compare fails RETRY_MAX+1 times on one word, the block stops with `error`, `err_code` 10 and `err_addr` equal to that word's address.
- R9: If `first_addr` is greater than `last_addr` at start, `done` rises with no bus access.
- R10: A `start` pulse while `busy` is high is ignored. The run in progress keeps its addresses and mode.
- R11: `fl_we` and `fl_re` are never high together, and a read cycle is always followed by a cycle with no strobe.
- R12: `done` and `error` are never high together. Each holds until the next accepted `start`, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run (accepted only when not busy) |
| bypass | input | 1 | Use the two-write program form for this run |
| first_addr | input | AW | First word address |
| last_addr | input | AW | Last word address |
| src_addr | output | AW | Address of the word currently being programmed |
| src_data | input | DW | Source word for `src_addr` |
| fl_we | output | 1 | Flash write strobe, one cycle per write |
| fl_re | output | 1 | Flash read strobe |
| fl_addr | output | AW | Flash address |
| fl_wdata | output | DW | Flash write data |
| fl_rdata | input | DW | Flash read data, valid the cycle after `fl_re` |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished without error |
| error | output | 1 | Run stopped on an error |
| err_code | output | 2 | 01 poll timeout, 10 compare failure, 00 none |
| err_addr | output | AW | Address of the word that failed |

## Verification
The hardest situation to reach from the ports is a word whose device status reports completion but whose read-back is wrong for a bounded number of reads. This drives the sequencer around the compare-and-repoll loop, right up to the retry limit and one failure past it. The bench's behavioural flash corrupts a non-status bit for a chosen number of reads after each word finishes. It can also hold a word busy forever to force the poll timeout. Directed runs place these conditions exactly on the retry boundary, and seeded random runs scatter them across ranges in both command forms.

// File: rtl/fps_pkg.sv
package fps_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_LOAD,
    S_CMD,
    S_PRD,
    S_PCHK,
    S_VRD,
    S_VCHK,
    S_DONE,
    S_ERR
  } fps_state_e;

  typedef logic [1:0] fps_err_t;

  localparam fps_err_t ERR_NONE = 2'b00;
  localparam fps_err_t ERR_TMO  = 2'b01;
  localparam fps_err_t ERR_VFY  = 2'b10;

endpackage

// File: rtl/fps_limit_ctr.sv
module fps_limit_ctr #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic last
);

  localparam int W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] TOP = W'(LIMIT - 1);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)      cnt_d = '0;
    else if (inc) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign last = (cnt_q == TOP);

  // R7 / R8: the caller must stop at the limit instead of counting past it
  a_r7_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr) |-> !last);

  a_r8_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= TOP);

endmodule

// File: rtl/fps_addr_ctr.sv
module fps_addr_ctr #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] first,
  input  logic [AW-1:0] last,
  input  logic          inc,
  output logic [AW-1:0] cur,
  output logic          is_last
);

  logic [AW-1:0] cur_q, cur_d;
  logic [AW-1:0] end_q, end_d;

  always_comb begin
    cur_d = cur_q;
    end_d = end_q;
    if (load) begin
      cur_d = first;
      end_d = last;
    end else if (inc) begin
      cur_d = cur_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= '0;
      end_q <= '0;
    end else begin
      cur_q <= cur_d;
      end_q <= end_d;
    end
  end

  assign cur     = cur_q;
  assign is_last = (cur_q == end_q);

  // R6: never step beyond the last address of the range
  a_r6_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !load) |-> !is_last);

endmodule

// File: rtl/fps_cmd_seq.sv
module fps_cmd_seq #(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter logic [AW-1:0] UNLK_A = 16'h0555,
  parameter logic [AW-1:0] UNLK_B = 16'h02AA
) (
  input  logic          bypass,
  input  logic [1:0]    step,
  input  logic [AW-1:0] tgt_addr,
  input  logic [DW-1:0] tgt_data,
  output logic [AW-1:0] cmd_addr,
  output logic [DW-1:0] cmd_data,
  output logic          final_step
);

  localparam logic [DW-1:0] C_KEY1 = DW'(8'hAA);
  localparam logic [DW-1:0] C_KEY2 = DW'(8'h55);
  localparam logic [DW-1:0] C_PGM  = DW'(8'hA0);

  always_comb begin
    cmd_addr   = tgt_addr;
    cmd_data   = tgt_data;
    final_step = 1'b0;
    if (bypass) begin
      if (step == 2'd0) begin
        cmd_addr = UNLK_A;
        cmd_data = C_PGM;
      end else begin
        final_step = 1'b1;
      end
    end else begin
      case (step)
        2'd0: begin cmd_addr = UNLK_A; cmd_data = C_KEY1; end
        2'd1: begin cmd_addr = UNLK_B; cmd_data = C_KEY2; end
        2'd2: begin cmd_addr = UNLK_A; cmd_data = C_PGM;  end
        default: final_step = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/flash_prog_seq.sv
module flash_prog_seq
  import fps_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int POLL_LIMIT = 1024,
  parameter int RETRY_MAX = 3,
  parameter logic [AW-1:0] UNLK_A = 16'h0555,
  parameter logic [AW-1:0] UNLK_B = 16'h02AA
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          bypass,
  input  logic [AW-1:0] first_addr,
  input  logic [AW-1:0] last_addr,
  output logic [AW-1:0] src_addr,
  input  logic [DW-1:0] src_data,
  output logic          fl_we,
  output logic          fl_re,
  output logic [AW-1:0] fl_addr,
  output logic [DW-1:0] fl_wdata,
  input  logic [DW-1:0] fl_rdata,
  output logic          busy,
  output logic          done,
  output logic          error,
  output logic [1:0]    err_code,
  output logic [AW-1:0] err_addr
);

  localparam int STATUS_BIT = 7;

  // reset: asserted asynchronously, released on the clock
  logic rst_m_q, rst_s_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q <= 1'b0;
      rst_s_q <= 1'b0;
    end else begin
      rst_m_q <= 1'b1;
      rst_s_q <= rst_m_q;
    end
  end

  fps_state_e    state_q, state_d;
  logic [1:0]    step_q, step_d;
  logic          bypass_q, bypass_d;
  logic [DW-1:0] word_q;
  logic          word_en;
  fps_err_t      code_q, code_d;
  logic [AW-1:0] eaddr_q, eaddr_d;

  logic          idle_like, accept, empty_rng;
  logic          addr_load, addr_inc, cur_last;
  logic          poll_clr, poll_inc, poll_last;
  logic          rty_clr, rty_inc, rty_last;
  logic [AW-1:0] cur_addr, cmd_addr;
  logic [DW-1:0] cmd_data;
  logic          cmd_final;
  logic          poll_ok, vfy_ok;

  fps_addr_ctr #(.AW(AW)) u_addr (
    .clk(clk), .rst_n(rst_s_q), .load(addr_load), .first(first_addr),
    .last(last_addr), .inc(addr_inc), .cur(cur_addr), .is_last(cur_last)
  );

  fps_limit_ctr #(.LIMIT(POLL_LIMIT)) u_poll (
    .clk(clk), .rst_n(rst_s_q), .clr(poll_clr), .inc(poll_inc), .last(poll_last)
  );

  fps_limit_ctr #(.LIMIT(RETRY_MAX + 1)) u_retry (
    .clk(clk), .rst_n(rst_s_q), .clr(rty_clr), .inc(rty_inc), .last(rty_last)
  );

  fps_cmd_seq #(.AW(AW), .DW(DW), .UNLK_A(UNLK_A), .UNLK_B(UNLK_B)) u_cmd (
    .bypass(bypass_q), .step(step_q), .tgt_addr(cur_addr), .tgt_data(word_q),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .final_step(cmd_final)
  );

  assign idle_like = (state_q == S_IDLE) || (state_q == S_DONE) || (state_q == S_ERR);
  assign accept    = idle_like && start;
  assign empty_rng = first_addr > last_addr;
  assign poll_ok   = (fl_rdata[STATUS_BIT] == word_q[STATUS_BIT]);
  assign vfy_ok    = (fl_rdata == word_q);

  always_comb begin
    state_d   = state_q;
    step_d    = step_q;
    bypass_d  = bypass_q;
    code_d    = code_q;
    eaddr_d   = eaddr_q;
    word_en   = 1'b0;
    addr_load = 1'b0;
    addr_inc  = 1'b0;
    poll_clr  = 1'b0;
    poll_inc  = 1'b0;
    rty_clr   = 1'b0;
    rty_inc   = 1'b0;
    case (state_q)
      S_IDLE, S_DONE, S_ERR: begin
        if (accept) begin
          code_d   = ERR_NONE;
          bypass_d = bypass;
          if (empty_rng) begin
            state_d = S_DONE;
          end else begin
            addr_load = 1'b1;
            state_d   = S_LOAD;
          end
        end
      end
      S_LOAD: begin
        word_en = 1'b1;
        step_d  = 2'd0;
        rty_clr = 1'b1;
        state_d = S_CMD;
      end
      S_CMD: begin
        if (cmd_final) begin
          poll_clr = 1'b1;
          state_d  = S_PRD;
        end else begin
          step_d = step_q + 2'd1;
        end
      end
      S_PRD: state_d = S_PCHK;
      S_PCHK: begin
        if (poll_ok) begin
          state_d = S_VRD;
        end else if (poll_last) begin
          code_d  = ERR_TMO;
          eaddr_d = cur_addr;
          state_d = S_ERR;
        end else begin
          poll_inc = 1'b1;
          state_d  = S_PRD;
        end
      end
      S_VRD: state_d = S_VCHK;
      S_VCHK: begin
        if (vfy_ok) begin
          if (cur_last) begin
            state_d = S_DONE;
          end else begin
            addr_inc = 1'b1;
            state_d  = S_LOAD;
          end
        end else if (rty_last) begin
          code_d  = ERR_VFY;
          eaddr_d = cur_addr;
          state_d = S_ERR;
        end else begin
          rty_inc  = 1'b1;
          poll_clr = 1'b1;
          state_d  = S_PRD;
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s_q) begin
    if (!rst_s_q) begin
      state_q  <= S_IDLE;
      step_q   <= 2'd0;
      bypass_q <= 1'b0;
      word_q   <= '0;
      code_q   <= ERR_NONE;
      eaddr_q  <= '0;
    end else begin
      state_q  <= state_d;
      step_q   <= step_d;
      bypass_q <= bypass_d;
      code_q   <= code_d;
      eaddr_q  <= eaddr_d;
      if (word_en) word_q <= src_data;
    end
  end

  assign src_addr = cur_addr;
  assign fl_we    = (state_q == S_CMD);
  assign fl_re    = (state_q == S_PRD) || (state_q == S_VRD);
  assign fl_addr  = fl_we ? cmd_addr : cur_addr;
  assign fl_wdata = fl_we ? cmd_data : '0;
  assign busy     = !idle_like;
  assign done     = (state_q == S_DONE);
  assign error    = (state_q == S_ERR);
  assign err_code = code_q;
  assign err_addr = eaddr_q;

  a_r11_no_overlap: assert property (@(posedge clk) disable iff (!rst_s_q)
    !(fl_we && fl_re));

  a_r11_read_gap: assert property (@(posedge clk) disable iff (!rst_s_q)
    fl_re |=> (!fl_re && !fl_we));

  a_r12_exclusive: assert property (@(posedge clk) disable iff (!rst_s_q)
    !(done && error));

  a_r7_quiet_on_error: assert property (@(posedge clk) disable iff (!rst_s_q)
    error |-> (!fl_we && !fl_re));

  a_r10_busy_holds: assert property (@(posedge clk) disable iff (!rst_s_q)
    (busy && start) |=> (busy || done || error));

endmodule

// File: tb/flash_prog_seq_bench.sv
module flash_prog_seq_bench;

  localparam int CLK_P = 10;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam int PLIM = 16;
  localparam int RMAX = 2;

  logic          clk, rst_n, start, bypass;
  logic [AW-1:0] first_addr, last_addr, src_addr, fl_addr, err_addr;
  logic [DW-1:0] src_data, fl_wdata, fl_rdata;
  logic          fl_we, fl_re, busy, done, error;
  logic [1:0]    err_code;
  logic [15:0]   salt;

  int checks = 0;
  int fails  = 0;

  flash_prog_seq #(.AW(AW), .DW(DW), .POLL_LIMIT(PLIM), .RETRY_MAX(RMAX)) u_flash_prog_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .bypass(bypass),
    .first_addr(first_addr), .last_addr(last_addr), .src_addr(src_addr),
    .src_data(src_data), .fl_we(fl_we), .fl_re(fl_re), .fl_addr(fl_addr),
    .fl_wdata(fl_wdata), .fl_rdata(fl_rdata), .busy(busy), .done(done),
    .error(error), .err_code(err_code), .err_addr(err_addr)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  assign src_data = (src_addr * 16'h9E37) ^ salt;

  function automatic logic [15:0] exp_data(input int a);
    logic [15:0] aa;
    aa = 16'(a);
    return (aa * 16'h9E37) ^ salt;
  endfunction

  // behavioural flash responder
  logic [15:0] mem [64];
  int  busy_len [64];
  bit  stuck [64];
  int  flip [64];
  bit  resp_bp;
  int  ph, busy_left, post_rc, cur_a;
  bit  cur_stuck;
  int  wr_cnt, rd_cnt, word_rd, proto_err, overlap;

  always @(posedge clk) begin
    if (fl_we && fl_re) overlap++;
    if (fl_we) begin
      wr_cnt++;
      if (ph == 3) begin
        cur_a         = int'(fl_addr[5:0]);
        mem[cur_a]    = fl_wdata;
        busy_left     = busy_len[cur_a];
        cur_stuck     = stuck[cur_a];
        post_rc       = 0;
        word_rd       = 0;
        ph            = 0;
        if (fl_addr > 16'd63) proto_err++;
      end else if (!resp_bp && ph == 0 && fl_addr == 16'h555 && fl_wdata == 16'hAA) ph = 1;
      else if (!resp_bp && ph == 1 && fl_addr == 16'h2AA && fl_wdata == 16'h55) ph = 2;
      else if (!resp_bp && ph == 2 && fl_addr == 16'h555 && fl_wdata == 16'hA0) ph = 3;
      else if (resp_bp && ph == 0 && fl_addr == 16'h555 && fl_wdata == 16'hA0) ph = 3;
      else begin
        proto_err++;
        ph = 0;
      end
    end
    if (fl_re) begin
      rd_cnt++;
      word_rd++;
      if (int'(fl_addr) != cur_a) proto_err++;
      if (cur_stuck || busy_left > 0) fl_rdata <= ~mem[cur_a];
      else begin
        fl_rdata <= (post_rc < flip[cur_a]) ? (mem[cur_a] ^ 16'h0100) : mem[cur_a];
        post_rc++;
      end
    end
    if (busy_left > 0) busy_left--;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  task automatic clear_faults();
    for (int i = 0; i < 64; i++) begin
      busy_len[i] = 5;
      stuck[i]    = 1'b0;
      flip[i]     = 0;
    end
  endtask

  // run one range and compare against the model prediction
  task automatic run(input int f, input int l, input bit bp, input bit poke);
    int exp_kind, exp_fail, exp_words, n, wr0, rd0;
    logic [15:0] sentinel;
    salt     = 16'($urandom);
    sentinel = 16'hA5A5 ^ salt;
    for (int i = 0; i < 64; i++) mem[i] = sentinel;
    exp_kind = 0; exp_fail = 0; exp_words = 0;
    if (f <= l) begin
      for (int a = f; a <= l; a++) begin
        exp_words++;
        if (stuck[a]) begin exp_kind = 1; exp_fail = a; break; end
        if (flip[a] / 2 > RMAX) begin exp_kind = 2; exp_fail = a; break; end
      end
    end
    @(negedge clk);
    wr_cnt = 0; rd_cnt = 0; proto_err = 0; overlap = 0; ph = 0;
    resp_bp = bp; cur_a = 0; cur_stuck = 1'b0; busy_left = 0;
    first_addr = 16'(f); last_addr = 16'(l); bypass = bp; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (f <= l) begin
      chk(busy && !done && !error, "R12", "cleared after start", int'({busy, done, error}), 4);
    end
    if (poke) begin
      repeat (3) @(negedge clk);
      first_addr = 16'd0; last_addr = 16'd63; bypass = ~bp; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    n = 0;
    while (!(done || error) && n < 20000) begin
      @(negedge clk);
      n++;
    end
    if (exp_kind == 0) begin
      chk(done && !error && !busy, "R6", "done status", int'({done, error, busy}), 4);
      chk(err_code == 2'b00, "R6", "err_code", int'(err_code), 0);
    end else begin
      chk(error && !done, exp_kind == 1 ? "R7" : "R8", "error status", int'({done, error}), 1);
      chk(int'(err_code) == exp_kind, exp_kind == 1 ? "R7" : "R8", "err_code",
          int'(err_code), exp_kind);
      chk(int'(err_addr) == exp_fail, exp_kind == 1 ? "R7" : "R8", "err_addr",
          int'(err_addr), exp_fail);
      if (exp_kind == 1) chk(word_rd == PLIM, "R7", "poll reads before timeout", word_rd, PLIM);
      wr0 = wr_cnt; rd0 = rd_cnt;
      repeat (5) @(negedge clk);
      chk(wr_cnt == wr0 && rd_cnt == rd0, "R7", "bus quiet after error",
          wr_cnt + rd_cnt, wr0 + rd0);
    end
    chk(wr_cnt == exp_words * (bp ? 2 : 4), bp ? "R3" : "R2", "write count",
        wr_cnt, exp_words * (bp ? 2 : 4));
    chk(proto_err == 0, bp ? "R3" : "R2", "command/read address errors (R4)", proto_err, 0);
    chk(overlap == 0, "R11", "strobe overlap", overlap, 0);
    if (f <= l) begin
      for (int a = f; a <= l; a++) begin
        if (exp_kind == 0 || a < exp_fail) begin
          chk(mem[a] == exp_data(a), "R6", $sformatf("word %0d", a), int'(mem[a]), int'(exp_data(a)));
        end else if (a > exp_fail) begin
          chk(mem[a] == sentinel, "R6", $sformatf("untouched %0d", a), int'(mem[a]), int'(sentinel));
        end
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; start = 1'b0; bypass = 1'b0;
    first_addr = '0; last_addr = '0; salt = 16'h0;
    fl_rdata = '0;
    ph = 0; busy_left = 0; cur_a = 0; cur_stuck = 1'b0; post_rc = 0;
    wr_cnt = 0; rd_cnt = 0; word_rd = 0; proto_err = 0; overlap = 0; resp_bp = 1'b0;
    clear_faults();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !error && !fl_we && !fl_re && err_code == 2'b00, "R1",
        "reset state", int'({busy, done, error, fl_we, fl_re}), 0);

    // R2 full form, R3 short form
    run(4, 6, 1'b0, 1'b0);
    run(10, 13, 1'b1, 1'b0);
    // R4 device ready on first poll
    busy_len[20] = 0;
    run(20, 20, 1'b0, 1'b0);
    // R5 compare fails exactly RETRY_MAX times, word still completes
    clear_faults();
    flip[31] = 2 * RMAX;
    run(30, 32, 1'b0, 1'b0);
    // R8 one compare failure beyond the limit
    flip[31] = 2 * RMAX + 2;
    run(30, 33, 1'b1, 1'b0);
    // R7 a word that never finishes
    clear_faults();
    stuck[42] = 1'b1;
    run(40, 45, 1'b0, 1'b0);
    // R9 empty range
    clear_faults();
    run(9, 8, 1'b0, 1'b0);
    chk(done && wr_cnt == 0 && rd_cnt == 0, "R9", "empty range bus cycles", wr_cnt + rd_cnt, 0);
    // R10 start pulse during a run
    run(50, 53, 1'b0, 1'b1);
    run(50, 52, 1'b1, 1'b1);
    // R12 done holds until the next start
    repeat (6) @(negedge clk);
    chk(done && !error, "R12", "done held", int'({done, error}), 2);

    for (int r = 0; r < 40; r++) begin
      int f;
      for (int i = 0; i < 64; i++) begin
        busy_len[i] = $urandom_range(0, 12);
        stuck[i]    = ($urandom_range(0, 19) == 0);
        flip[i]     = ($urandom_range(0, 3) == 0) ? $urandom_range(1, 7) : 0;
      end
      f = $urandom_range(0, 55);
      run(f, f + $urandom_range(0, 7), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
    end

    summary();
    $finish;
  end

endmodule